// File: doc/BRIEF.md
# Multi-Error ECC Fixup Sequencer

This block applies the outcome of a four-error-correcting syndrome decoder to a 512-byte sector buffer. It takes a start request. It first looks at the ten stored ECC bytes; if all of them are 0xFF, the sector is taken to be erased and nothing more happens. If the four syndrome words are all zero, the sector is clean and the decoder is never started. In every other case the block pulses a start to the error locator. It then polls the locator's correction state, first until that state shows busy and then until it shows a final code.

With a final code of 2 or 3, the block walks the reported error entries in order. Each reported address counts down from 519, so the block mirrors it into a buffer index. Entries that land on the parity bytes, or outside the sector, are skipped. Every remaining entry is applied as a read-modify-write: a read cycle, then on the next cycle a write of the read byte XOR the error value. When the block finishes, it pulses `done_o` and holds its result flags and correction count until the next start.

Top module: `ecc_fixup_seq`

## Requirements
- R1: When all ten bytes of `stored_ecc_i` equal 0xFF at start, the block finishes with `erased_o`=1, `uncorr_o`=0, `timeout_o`=0 and `fixed_cnt_o`=0. It raises no `calc_start_o` and performs no buffer access. A single byte differing from 0xFF disables this path.
- R2: When `stored_ecc_i` is not all 0xFF and all four 10-bit syndrome words in `syndrome_i` are zero, the block finishes clean with all flags 0. It raises no `calc_start_o` and performs no buffer access.
- R3: Otherwise the block gives exactly one single-cycle `calc_start_o` pulse. It then waits until the state field `status_i[11:8]` leaves 0..3, and after that until the field returns to 0..3. A final code left over from before the start is never trusted.
- R4: Each of the two waits lasts at most TIMEOUT polls. If either wait expires, the block finishes with `timeout_o`=1, `uncorr_o`=0, `fixed_cnt_o`=0 and no buffer access.
- R5: Final code 1 (too many errors) finishes with `uncorr_o`=1, `fixed_cnt_o`=0 and no buffer access.
- R6: Final code 0 finishes clean with no buffer access, whatever the error count field holds.
- R7: For final codes 2 and 3, the error count is `status_i[18:16]`, and values above 4 are treated as 4. Entry i takes its address from bits [9:0] of the 16-bit half at offset 16*(i&1) of 32-bit address word i>>1 in `err_addr_i`. It takes its value from bits [7:0] of the same half of `err_val_i`. The upper bits of each half are ignored.
- R8: The buffer index of an entry is 519 minus its reported address. The entry is applied only when the address lies in 8..519, so that the index is below 512; all other entries are skipped.
- R9: Each applied entry produces a read cycle (`buf_rd_o`) and, on the next cycle, a write (`buf_wr_o`) of `buf_rdata_i` XOR the value to the same index. Entries are applied one at a time in entry order, so repeated indices accumulate. `fixed_cnt_o` equals the number of writes.
- R10: `done_o` is high for exactly one cycle per operation. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one fixup operation (sampled when idle) |
| stored_ecc_i | input | 80 | Ten stored ECC bytes, byte k at bits [8k+7:8k] |
| syndrome_i | input | 40 | Four 10-bit syndrome words |
| status_i | input | 32 | Locator status: state at [11:8], error count at [18:16] |
| err_addr_i | input | 64 | Two 32-bit error address words, two entries each |
| err_val_i | input | 64 | Two 32-bit error value words, two entries each |
| buf_rdata_i | input | 8 | Sector buffer read data, valid the cycle after a read |
| calc_start_o | output | 1 | One-cycle start of address calculation |
| buf_rd_o | output | 1 | Sector buffer read strobe |
| buf_wr_o | output | 1 | Sector buffer write strobe |
| buf_addr_o | output | 9 | Sector buffer byte index |
| buf_wdata_o | output | 8 | Sector buffer write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| erased_o | output | 1 | Last operation saw an erased sector |
| uncorr_o | output | 1 | Last operation was uncorrectable |
| timeout_o | output | 1 | Last operation hit a polling timeout |
| fixed_cnt_o | output | 3 | Bytes corrected by the last operation |

## Verification
A single error is swept over every one of the 1024 possible reported addresses. This separates the mirrored, applied window 8..519 from the parity bytes below it and from the addresses past the sector. Four-entry patterns carry garbage in the unused upper bits and hit the same index twice, so they separate correct field extraction and ordered accumulation from a parallel or unmasked implementation. Count values of 0, 2, 4 and 7 expose the clamp. Stale final codes, locators that never go busy or never settle, and ECC bytes that miss all-0xFF by a single bit tell the waiting, timeout and erased paths apart.

// File: rtl/ecc_fixup_pkg.sv
package ecc_fixup_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_SETTLE,
      ST_PICK,
      ST_RD,
      ST_WR,
      ST_DONE
   } fix_state_e;

   localparam logic [3:0] CODE_CLEAN  = 4'd0;
   localparam logic [3:0] CODE_UNCORR = 4'd1;
   localparam logic [3:0] CODE_LAST   = 4'd3;
endpackage

// File: rtl/erase_detect.sv
module erase_detect #(
   parameter int NBYTES = 10
) (
   input  logic [NBYTES*8-1:0] bytes_i,
   output logic                all_ones_o
);
   logic [NBYTES-1:0] byte_full;

   for (genvar k = 0; k < NBYTES; k++) begin : g_byte
      assign byte_full[k] = &bytes_i[k*8 +: 8];
   end

   assign all_ones_o = &byte_full;
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
   parameter int LIMIT = 10240
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic tick_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = tick_i && (cnt_q == LAST);
endmodule

// File: rtl/err_entry_sel.sv
module err_entry_sel #(
   parameter int ADDR_W = 10,
   parameter int VAL_W  = 8,
   parameter int SECTOR = 512,
   parameter int BIAS   = 519,
   parameter int IDX_W  = 9
) (
   input  logic [1:0]       sel_i,
   input  logic [63:0]      addr_words_i,
   input  logic [63:0]      val_words_i,
   output logic [IDX_W-1:0] idx_o,
   output logic [VAL_W-1:0] val_o,
   output logic             hit_o
);
   localparam int LOW_EDGE = BIAS - SECTOR + 1;

   logic [31:0]       a_word, v_word;
   logic [15:0]       a_half, v_half;
   logic [ADDR_W-1:0] raw;
   logic [ADDR_W:0]   diff;

   always_comb begin
      a_word = sel_i[1] ? addr_words_i[63:32] : addr_words_i[31:0];
      v_word = sel_i[1] ? val_words_i[63:32]  : val_words_i[31:0];
      a_half = sel_i[0] ? a_word[31:16] : a_word[15:0];
      v_half = sel_i[0] ? v_word[31:16] : v_word[15:0];
      raw    = a_half[ADDR_W-1:0];
      val_o  = v_half[VAL_W-1:0];
      diff   = (ADDR_W+1)'(BIAS) - {1'b0, raw};
      idx_o  = diff[IDX_W-1:0];
      hit_o  = (int'(raw) >= LOW_EDGE) && (int'(raw) <= BIAS);
   end
endmodule

// File: rtl/ecc_fixup_seq.sv
module ecc_fixup_seq
   import ecc_fixup_pkg::*;
#(
   parameter int ECC_BYTES = 10,
   parameter int SYN_WORDS = 4,
   parameter int SYN_W     = 10,
   parameter int SECTOR    = 512,
   parameter int ADDR_W    = 10,
   parameter int VAL_W     = 8,
   parameter int STATE_LSB = 8,
   parameter int CNT_LSB   = 16,
   parameter int CNT_W     = 3,
   parameter int MAX_ERR   = 4,
   parameter int TIMEOUT   = 10240
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [ECC_BYTES*8-1:0]  stored_ecc_i,
   input  logic [SYN_WORDS*SYN_W-1:0] syndrome_i,
   input  logic [31:0]             status_i,
   input  logic [63:0]             err_addr_i,
   input  logic [63:0]             err_val_i,
   input  logic [VAL_W-1:0]        buf_rdata_i,
   output logic                    calc_start_o,
   output logic                    buf_rd_o,
   output logic                    buf_wr_o,
   output logic [$clog2(SECTOR)-1:0] buf_addr_o,
   output logic [VAL_W-1:0]        buf_wdata_o,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    erased_o,
   output logic                    uncorr_o,
   output logic                    timeout_o,
   output logic [$clog2(MAX_ERR+1)-1:0] fixed_cnt_o
);
   localparam int IDX_W = $clog2(SECTOR);
   localparam int FIX_W = $clog2(MAX_ERR + 1);
   localparam int BIAS  = SECTOR + 7;

   if (MAX_ERR < 1 || MAX_ERR > 4) begin : g_bad_maxerr
      $error("MAX_ERR must be 1..4: two words of two entries");
   end
   if (ADDR_W > 16 || VAL_W > 16) begin : g_bad_field
      $error("entry fields must fit a 16-bit half word");
   end
   if (BIAS >= (1 << ADDR_W)) begin : g_bad_bias
      $error("ADDR_W too narrow for the sector size");
   end

   fix_state_e       state_q;
   logic             erased_w, syn_zero, final_w, tmr_exp, tmr_clr, tmr_tick;
   logic [3:0]       code_w;
   logic [CNT_W-1:0] cnt_field;
   logic [FIX_W-1:0] n_err_w, n_err_q, ent_q, fixed_q;
   logic [IDX_W-1:0] sel_idx, cur_idx_q;
   logic [VAL_W-1:0] sel_val, cur_val_q;
   logic             sel_hit, calc_q, erased_q, uncorr_q, timeout_q;

   erase_detect #(.NBYTES(ECC_BYTES)) u_erase (
      .bytes_i    (stored_ecc_i),
      .all_ones_o (erased_w)
   );

   poll_timer #(.LIMIT(TIMEOUT)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (tmr_clr),
      .tick_i    (tmr_tick),
      .expired_o (tmr_exp)
   );

   err_entry_sel #(
      .ADDR_W(ADDR_W), .VAL_W(VAL_W), .SECTOR(SECTOR), .BIAS(BIAS), .IDX_W(IDX_W)
   ) u_sel (
      .sel_i        (ent_q[1:0]),
      .addr_words_i (err_addr_i),
      .val_words_i  (err_val_i),
      .idx_o        (sel_idx),
      .val_o        (sel_val),
      .hit_o        (sel_hit)
   );

   always_comb begin
      syn_zero  = (syndrome_i == '0);
      code_w    = status_i[STATE_LSB +: 4];
      final_w   = (code_w <= CODE_LAST);
      cnt_field = status_i[CNT_LSB +: CNT_W];
      n_err_w   = (int'(cnt_field) > MAX_ERR) ? FIX_W'(MAX_ERR) : FIX_W'(cnt_field);
      tmr_tick  = (state_q == ST_ARM) || (state_q == ST_SETTLE);
      tmr_clr   = (state_q == ST_IDLE) || ((state_q == ST_ARM) && !final_w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         calc_q    <= 1'b0;
         erased_q  <= 1'b0;
         uncorr_q  <= 1'b0;
         timeout_q <= 1'b0;
         fixed_q   <= '0;
         n_err_q   <= '0;
         ent_q     <= '0;
         cur_idx_q <= '0;
         cur_val_q <= '0;
      end else begin
         calc_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               erased_q  <= 1'b0;
               uncorr_q  <= 1'b0;
               timeout_q <= 1'b0;
               fixed_q   <= '0;
               if (erased_w) begin
                  erased_q <= 1'b1;
                  state_q  <= ST_DONE;
               end else if (syn_zero) begin
                  state_q  <= ST_DONE;
               end else begin
                  calc_q   <= 1'b1;
                  state_q  <= ST_ARM;
               end
            end
            ST_ARM: begin
               if (!final_w)     state_q <= ST_SETTLE;
               else if (tmr_exp) begin
                  timeout_q <= 1'b1;
                  state_q   <= ST_DONE;
               end
            end
            ST_SETTLE: begin
               if (final_w) begin
                  if (code_w == CODE_UNCORR) begin
                     uncorr_q <= 1'b1;
                     state_q  <= ST_DONE;
                  end else if (code_w == CODE_CLEAN) begin
                     state_q  <= ST_DONE;
                  end else begin
                     n_err_q  <= n_err_w;
                     ent_q    <= '0;
                     state_q  <= ST_PICK;
                  end
               end else if (tmr_exp) begin
                  timeout_q <= 1'b1;
                  state_q   <= ST_DONE;
               end
            end
            ST_PICK: begin
               if (ent_q >= n_err_q) begin
                  state_q <= ST_DONE;
               end else if (sel_hit) begin
                  cur_idx_q <= sel_idx;
                  cur_val_q <= sel_val;
                  state_q   <= ST_RD;
               end else begin
                  ent_q <= ent_q + 1'b1;
               end
            end
            ST_RD: state_q <= ST_WR;
            ST_WR: begin
               fixed_q <= fixed_q + 1'b1;
               ent_q   <= ent_q + 1'b1;
               state_q <= ST_PICK;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign calc_start_o = calc_q;
   assign buf_rd_o     = (state_q == ST_RD);
   assign buf_wr_o     = (state_q == ST_WR);
   assign buf_addr_o   = cur_idx_q;
   assign buf_wdata_o  = buf_rdata_i ^ cur_val_q;
   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = (state_q == ST_DONE);
   assign erased_o     = erased_q;
   assign uncorr_o     = uncorr_q;
   assign timeout_o    = timeout_q;
   assign fixed_cnt_o  = fixed_q;
endmodule

// File: rtl/ecc_fixup_chk.sv
module ecc_fixup_chk #(
   parameter int IDX_W = 9,
   parameter int FIX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             calc_start_o,
   input logic             buf_rd_o,
   input logic             buf_wr_o,
   input logic [IDX_W-1:0] buf_addr_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             erased_o,
   input logic             uncorr_o,
   input logic             timeout_o,
   input logic [FIX_W-1:0] fixed_cnt_o
);
   // R9
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(buf_rd_o && buf_wr_o));
   // R9
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd_o |=> buf_wr_o);
   // R9
   wr_same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_o |-> $past(buf_rd_o) && (buf_addr_o == $past(buf_addr_o)));
   // R3
   calc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      calc_start_o |=> !calc_start_o && busy_o);
   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !buf_rd_o && !buf_wr_o && !calc_start_o);
   // R1
   erased_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && erased_o) |-> (fixed_cnt_o == '0) && !uncorr_o && !timeout_o);
   // R4
   timeout_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && timeout_o) |-> (fixed_cnt_o == '0) && !uncorr_o);
   // R5
   uncorr_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && uncorr_o) |-> (fixed_cnt_o == '0));
endmodule

bind ecc_fixup_seq ecc_fixup_chk #(.IDX_W(IDX_W), .FIX_W(FIX_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .calc_start_o (calc_start_o),
   .buf_rd_o     (buf_rd_o),
   .buf_wr_o     (buf_wr_o),
   .buf_addr_o   (buf_addr_o),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .erased_o     (erased_o),
   .uncorr_o     (uncorr_o),
   .timeout_o    (timeout_o),
   .fixed_cnt_o  (fixed_cnt_o)
);

// File: tb/ecc_fixup_seq_tb.sv
module ecc_fixup_seq_tb_top;
   localparam int TMO = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [79:0] ecc = '0;
   logic [39:0] syn = '0;
   logic [3:0]  st = 4'd0;
   logic [2:0]  cnt = 3'd0;
   logic [63:0] addr_w = '0, val_w = '0;
   logic [7:0]  rdata = '0;
   logic        calc, rd, wr, busy, done, erased, uncorr, tmo;
   logic [8:0]  baddr;
   logic [7:0]  wdata;
   logic [2:0]  fixed;
   wire  [31:0] status = {13'd0, cnt, 4'd0, st, 8'd0};

   always #5 clk = ~clk;

   ecc_fixup_seq #(.TIMEOUT(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stored_ecc_i(ecc),
      .syndrome_i(syn), .status_i(status), .err_addr_i(addr_w),
      .err_val_i(val_w), .buf_rdata_i(rdata), .calc_start_o(calc),
      .buf_rd_o(rd), .buf_wr_o(wr), .buf_addr_o(baddr), .buf_wdata_o(wdata),
      .busy_o(busy), .done_o(done), .erased_o(erased), .uncorr_o(uncorr),
      .timeout_o(tmo), .fixed_cnt_o(fixed)
   );

   logic [7:0] mem [512];
   logic [7:0] refm [512];
   int n_wr, n_rd, n_calc, n_pass, n_fail;
   int m_cnt, m_bdly, m_fdly;
   bit m_on, m_nobusy, m_nofin;
   logic [3:0] m_fin;
   logic [9:0] e_addr [4];
   logic [7:0] e_val [4];

   always @(posedge clk) begin
      if (rd) begin rdata <= mem[baddr]; n_rd <= n_rd + 1; end
      if (wr) begin mem[baddr] <= wdata; n_wr <= n_wr + 1; end
      if (calc) n_calc <= n_calc + 1;
   end

   always @(negedge clk) begin
      if (calc) begin
         m_cnt = 0; m_on = 1'b1;
      end else if (m_on) begin
         m_cnt++;
         if (m_cnt == m_bdly && !m_nobusy) st = 4'hC;
         if (m_cnt == m_fdly && !m_nofin) begin st = m_fin; m_on = 1'b0; end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      if (ok) n_pass++;
      else begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pack_entries();
      for (int i = 0; i < 4; i++) begin
         addr_w[32*(i>>1) + 16*(i&1) +: 16] = {6'h2B, e_addr[i]};
         val_w[32*(i>>1) + 16*(i&1) +: 16]  = {8'hC3, e_val[i]};
      end
   endtask

   task automatic init_buf();
      for (int k = 0; k < 512; k++) begin
         mem[k] = 8'(k * 13 + 5);
         refm[k] = 8'(k * 13 + 5);
      end
   endtask

   // expected result of applying the first n entries (R7, R8)
   function automatic int apply_ref(input int n);
      int f = 0;
      int lim = (n > 4) ? 4 : n;
      for (int i = 0; i < lim; i++) begin
         if (e_addr[i] >= 8 && e_addr[i] <= 519) begin
            refm[519 - e_addr[i]] ^= e_val[i];
            f++;
         end
      end
      return f;
   endfunction

   function automatic int buf_mism();
      int m = 0;
      for (int k = 0; k < 512; k++) if (mem[k] !== refm[k]) m++;
      return m;
   endfunction

   task automatic run_op(input logic [79:0] e, input logic [39:0] s,
                         input logic [3:0] stale, input logic [3:0] fin,
                         input logic [2:0] c, input int bd, input int fd,
                         input bit nob, input bit nof);
      @(negedge clk);
      ecc = e; syn = s; st = stale; cnt = c;
      m_fin = fin; m_bdly = bd; m_fdly = fd; m_nobusy = nob; m_nofin = nof;
      m_on = 1'b0;
      n_wr = 0; n_rd = 0; n_calc = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int w = 0; w < 3000 && !done; w++) @(negedge clk);
   endtask

   initial begin
      n_pass = 0; n_fail = 0;
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
   end

   localparam logic [79:0] ALL_FF = {10{8'hFF}};
   localparam logic [39:0] SYN_NZ = 40'h00_0000_0040;
   int ef;

   initial begin
      for (int i = 0; i < 4; i++) begin e_addr[i] = '0; e_val[i] = '0; end
      pack_entries();
      init_buf();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(!done && !busy && !rd && !wr && !calc && !erased && !uncorr && !tmo
          && fixed == 0, "R10", "reset outputs", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 erased sector
      run_op(ALL_FF, SYN_NZ, 4'd3, 4'd3, 3'd1, 2, 5, 0, 0);
      chk(done === 1'b1, "R1", "done seen", int'(done), 1);
      chk(erased && !uncorr && !tmo && fixed == 0, "R1", "erased flags",
          int'(erased), 1);
      chk(n_calc == 0 && n_wr == 0 && n_rd == 0, "R1", "no activity", n_calc + n_rd, 0);
      @(negedge clk);
      // R10 single-cycle done, flags held
      chk(!done && erased, "R10", "done one cycle, flag held", int'(done), 0);

      // R1 near miss: byte 9 = 0xFE, final code 0
      run_op({8'hFE, {9{8'hFF}}}, SYN_NZ, 4'd1, 4'd0, 3'd2, 2, 5, 0, 0);
      chk(!erased && n_calc == 1, "R1", "near-miss not erased", int'(erased), 0);
      // R6 code 0 ignores count
      chk(!uncorr && !tmo && fixed == 0 && n_wr == 0, "R6", "code 0 clean", n_wr, 0);

      // R2 zero syndrome
      run_op(80'h1234, 40'd0, 4'd3, 4'd3, 3'd1, 2, 5, 0, 0);
      chk(n_calc == 0 && n_wr == 0 && !erased && !uncorr && !tmo, "R2",
          "zero syndrome", n_calc, 0);

      // R5 uncorrectable
      e_addr[0] = 10'd100; e_val[0] = 8'h01; pack_entries();
      run_op(80'h1234, SYN_NZ, 4'd0, 4'd1, 3'd1, 2, 6, 0, 0);
      chk(uncorr && !tmo && fixed == 0 && n_wr == 0, "R5", "uncorrectable", int'(uncorr), 1);
      chk(n_calc == 1, "R3", "one calc pulse", n_calc, 1);

      // R3 stale code 1 must not be trusted; real final code 3
      init_buf();
      ef = apply_ref(1);
      run_op(80'h1234, SYN_NZ, 4'd1, 4'd3, 3'd1, 20, 30, 0, 0);
      chk(!uncorr && fixed == 3'(ef), "R3", "stale code ignored", int'(fixed), ef);
      chk(buf_mism() == 0, "R3", "buffer after wait", buf_mism(), 0);

      // R4 never goes busy
      run_op(80'h1234, SYN_NZ, 4'd3, 4'd3, 3'd1, 2, 5, 1, 1);
      chk(tmo && !uncorr && fixed == 0 && n_wr == 0, "R4", "first wait timeout", int'(tmo), 1);
      // R4 busy forever
      st = 4'd0;
      run_op(80'h1234, SYN_NZ, 4'd3, 4'd3, 3'd1, 2, 5, 0, 1);
      chk(tmo && fixed == 0 && n_wr == 0, "R4", "second wait timeout", int'(tmo), 1);
      // R4 settles within limit: no timeout
      run_op(80'h1234, SYN_NZ, 4'd0, 4'd0, 3'd1, TMO - 5, 2 * TMO - 10, 0, 0);
      chk(!tmo, "R4", "slow but in time", int'(tmo), 0);

      // R8 R9 single-entry sweep over all addresses
      for (int a = 0; a < 1024; a++) begin
         init_buf();
         e_addr[0] = 10'(a); e_val[0] = 8'(a) ^ 8'h5A;
         pack_entries();
         ef = apply_ref(1);
         run_op(80'h55, SYN_NZ, 4'd0, (a[0] ? 4'd2 : 4'd3), 3'd1, 1, 3, 0, 0);
         chk(fixed == 3'(ef) && n_wr == ef, "R8", $sformatf("fix count addr %0d", a),
             int'(fixed), ef);
         chk(buf_mism() == 0, "R9", $sformatf("buffer addr %0d", a), buf_mism(), 0);
      end

      // R7 R9 four entries, duplicate index, skipped parity entry
      e_addr[0] = 10'd519; e_val[0] = 8'h01;
      e_addr[1] = 10'd8;   e_val[1] = 8'h80;
      e_addr[2] = 10'd3;   e_val[2] = 8'hFF;
      e_addr[3] = 10'd519; e_val[3] = 8'h10;
      pack_entries();
      for (int c = 0; c < 8; c++) begin
         init_buf();
         ef = apply_ref(c);
         run_op(80'h77, SYN_NZ, 4'd0, 4'd2, 3'(c), 2, 4, 0, 0);
         chk(fixed == 3'(ef), "R7", $sformatf("count %0d fixes", c), int'(fixed), ef);
         chk(buf_mism() == 0, "R9", $sformatf("count %0d buffer", c), buf_mism(), 0);
         chk(n_rd == n_wr, "R9", "reads match writes", n_rd, n_wr);
      end

      // R7 entries spread across both words and halves
      e_addr[0] = 10'd1023; e_val[0] = 8'h11;
      e_addr[1] = 10'd300;  e_val[1] = 8'h22;
      e_addr[2] = 10'd9;    e_val[2] = 8'h33;
      e_addr[3] = 10'd520;  e_val[3] = 8'h44;
      pack_entries();
      init_buf();
      ef = apply_ref(4);
      run_op(80'h77, SYN_NZ, 4'd0, 4'd3, 3'd4, 2, 4, 0, 0);
      chk(fixed == 3'(ef), "R7", "mixed entries fixes", int'(fixed), ef);
      chk(buf_mism() == 0, "R8", "mixed entries buffer", buf_mism(), 0);

      $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
      $finish;
   end
endmodule